// File: doc/BRIEF.md
# Program Counter and Dual Stack Unit

This unit holds the control-flow state of a small 8-bit processor core. It keeps a 14-bit program counter, a program stack pointer for call and interrupt frames, and a data stack pointer for push and pop. The instruction decoder sends it one operation at a time. The unit then drives a single-port 256-byte RAM to save or restore the bytes that operation needs. Decoding and arithmetic are done elsewhere.

The program counter is split into two parts. Its low byte advances on every sequential step. Its six page bits advance only when an explicit page operation is issued.

Call and interrupt frames are two bytes each. They are written at rising addresses starting from RAM address 0x00. The data stack grows the other way: each push first lowers its pointer and then writes, so the first push after reset lands at 0xFF.

Each memory-using operation keeps `busy_o` high until it is done. Any request made while busy is ignored.

Top module: `pcs_top`

## Requirements
- R1: After a synchronous active-low reset, the program counter, both stack pointers and both restored flags are zero, and `busy_o` is low.
- R2: A step operation adds one to program counter bits [7:0], wrapping from 0xFF to 0x00, and leaves bits [13:8] unchanged.
- R3: A page operation adds one to bits [13:8], wrapping modulo 64, and also adds one to bits [7:0], wrapping modulo 256.
- R4: A call or an interrupt acknowledge saves a two-byte frame, and the saved program counter is the value held when the operation is accepted.
  - In the first busy cycle it writes PC[7:0] at address PSP.
  - In the second busy cycle it writes {C, Z, PC[13:8]} (C in bit 7, Z in bit 6) at address PSP+1.
  - PSP ends two higher, and the program counter then holds `op_target_i`.
- R5: Return-from-interrupt reads address PSP-1 (the high frame byte) and then address PSP-2 (the low frame byte). It restores the program counter and both flags, and PSP ends two lower.
- R6: Return-from-subroutine performs the same two reads and restores the program counter only. The flags keep their previous values.
- R7: A push writes `op_data_i` at address DSP-1 and leaves DSP one lower, so the first push after reset writes address 0xFF.
- R8: A pop reads address DSP and leaves DSP one higher. The byte read appears on `pop_data_o` while `pop_valid_o` is high, in the second busy cycle.
- R9: The direct load operations put `op_data_i` into PSP or DSP in one cycle, without becoming busy.
- R10: All pointer arithmetic wraps modulo 256. For example, a frame saved with PSP=0xFF writes addresses 0xFF and 0x00 and leaves PSP=0x01.
- R11: `busy_o` stays high for 2 cycles on a call or interrupt acknowledge, 3 cycles on either return, 1 cycle on a push and 2 cycles on a pop. While it is high, `op_valid_i` is ignored.
- R12: The `op_code_i` encodings are: 0 none, 1 step, 2 page, 3 call, 4 interrupt acknowledge, 5 return-from-subroutine, 6 return-from-interrupt, 7 push, 8 pop, 9 load PSP, 10 load DSP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid_i | input | 1 | Operation request, taken only while not busy |
| op_code_i | input | 4 | Operation code (see R12) |
| op_data_i | input | 8 | Push data or pointer load value |
| op_target_i | input | 14 | Call target or interrupt vector |
| c_in_i | input | 1 | Carry flag to be saved in a frame |
| z_in_i | input | 1 | Zero flag to be saved in a frame |
| pc_o | output | 14 | Current program counter |
| c_o | output | 1 | Carry flag restored by return-from-interrupt |
| z_o | output | 1 | Zero flag restored by return-from-interrupt |
| busy_o | output | 1 | Multi-cycle operation in progress |
| psp_o | output | 8 | Program stack pointer |
| dsp_o | output | 8 | Data stack pointer |
| pop_data_o | output | 8 | Byte returned by a pop |
| pop_valid_o | output | 1 | `pop_data_o` is valid |
| mem_en_o | output | 1 | RAM access enable |
| mem_we_o | output | 1 | RAM write enable |
| mem_addr_o | output | 8 | RAM address |
| mem_wdata_o | output | 8 | RAM write data |
| mem_rdata_i | input | 8 | RAM read data, valid one cycle after a read |

## Verification
The bench saves frames across the 0xFF to 0x00 pointer boundary. A design that did not wrap would write outside the RAM or leave a wrong PSP, and the return from that frame would restore garbage.

It nests an interrupt frame on top of a call frame and then unwinds both. A design that swapped the byte order, or that let a subroutine return restore the flags, would end with a wrong counter or wrong flag values.

A step from low byte 0xFF and a page operation from page 0x3F are both applied. A counter that carried into the page bits on a step, or that failed to wrap the page, is caught.

A step is also held during a busy push. A design that accepted requests while busy would move the counter.

// File: rtl/pcs_pkg.sv
// Package: shared widths, operation codes and sequencer states for the
// program counter and dual stack unit.
package pcs_pkg;

    localparam int PCS_PC_W   = 14;
    localparam int PCS_LO_W   = 8;
    localparam int PCS_PTR_W  = 8;
    localparam int PCS_DATA_W = 8;

    // Operation codes presented by the decoder (encoding fixed by R12).
    typedef enum logic [3:0] {
        OP_NOP    = 4'd0,
        OP_STEP   = 4'd1,
        OP_PAGE   = 4'd2,
        OP_CALL   = 4'd3,
        OP_INTACK = 4'd4,
        OP_RET    = 4'd5,
        OP_RETI   = 4'd6,
        OP_PUSH   = 4'd7,
        OP_POP    = 4'd8,
        OP_LDPSP  = 4'd9,
        OP_LDDSP  = 4'd10
    } op_e;

    // Sequencer states; every state except ST_IDLE is a busy cycle.
    typedef enum logic [3:0] {
        ST_IDLE   = 4'd0,
        ST_SAV_LO = 4'd1,
        ST_SAV_HI = 4'd2,
        ST_RD_HI  = 4'd3,
        ST_RD_LO  = 4'd4,
        ST_RD_FIN = 4'd5,
        ST_PUSH   = 4'd6,
        ST_POP_RD = 4'd7,
        ST_POP_DT = 4'd8
    } st_e;

endpackage

// File: rtl/pcs_pc.sv
// Module: pcs_pc
// Holds the program counter. The low byte advances on a step. A page
// operation advances both the page field and the low byte. A load takes
// priority over a page operation, and a page operation over a step.
// Assumes the requests are already qualified by the sequencer (never
// asserted while busy, except the load, which the sequencer issues).
module pcs_pc #(
    parameter int PC_W = 14,
    parameter int LO_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_i,
    input  logic            page_i,
    input  logic            load_i,
    input  logic [PC_W-1:0] load_val_i,
    output logic [PC_W-1:0] pc_o
);

    localparam int PAGE_W = PC_W - LO_W;

    logic [LO_W-1:0]   lo_q;
    logic [PAGE_W-1:0] page_q;

    // Program counter register with load, page and step updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= '0;
            page_q <= '0;
        end else if (load_i) begin
            lo_q   <= load_val_i[LO_W-1:0];
            page_q <= load_val_i[PC_W-1:LO_W];
        end else if (page_i) begin
            lo_q   <= lo_q + 1'b1;
            page_q <= page_q + 1'b1;
        end else if (step_i) begin
            lo_q   <= lo_q + 1'b1;
        end
    end

    assign pc_o = {page_q, lo_q};

    AST_STEP_KEEPS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !page_i && !load_i) |=> (pc_o[PC_W-1:LO_W] == $past(pc_o[PC_W-1:LO_W]))); // R2

    AST_PAGE_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (page_i && !load_i) |=> (pc_o[PC_W-1:LO_W] == PAGE_W'($past(pc_o[PC_W-1:LO_W]) + 1'b1))); // R3

endmodule

// File: rtl/pcs_ptr.sv
// Module: pcs_ptr
// Stack pointer register with direct load, increment and decrement, all
// wrapping modulo 2**W. Priority: load, then increment, then decrement.
// Assumes the sequencer never asks for increment and decrement together.
module pcs_ptr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    input  logic         inc_i,
    input  logic         dec_i,
    output logic [W-1:0] ptr_o
);

    logic [W-1:0] ptr_q;

    // Pointer register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ld_i) begin
            ptr_q <= ld_val_i;
        end else if (inc_i) begin
            ptr_q <= ptr_q + 1'b1;
        end else if (dec_i) begin
            ptr_q <= ptr_q - 1'b1;
        end
    end

    assign ptr_o = ptr_q;

    AST_PTR_INC_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !ld_i) |=> (ptr_o == W'($past(ptr_o) + 1'b1))); // R10

    AST_PTR_DEC_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !ld_i && !inc_i) |=> (ptr_o == W'($past(ptr_o) - 1'b1))); // R10

endmodule

// File: rtl/pcs_seq.sv
// Module: pcs_seq
// Operation sequencer. It accepts one request while idle and steps through
// the memory cycles of frame saves, frame restores, pushes and pops. It
// drives the single-port RAM and tells the counter and the pointers when to
// move. Assumes a RAM whose read data arrives one cycle after the address.
module pcs_seq
    import pcs_pkg::*;
#(
    parameter int PC_W  = 14,
    parameter int LO_W  = 8,
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid_i,
    input  logic [3:0]       op_code_i,
    input  logic [7:0]       op_data_i,
    input  logic [PC_W-1:0]  op_target_i,
    input  logic             c_in_i,
    input  logic             z_in_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic [PTR_W-1:0] psp_i,
    input  logic [PTR_W-1:0] dsp_i,
    input  logic [7:0]       mem_rdata_i,
    output logic             busy_o,
    output logic             step_o,
    output logic             page_o,
    output logic             pc_ld_o,
    output logic [PC_W-1:0]  pc_ld_val_o,
    output logic             psp_ld_o,
    output logic             psp_inc_o,
    output logic             psp_dec_o,
    output logic             dsp_ld_o,
    output logic             dsp_inc_o,
    output logic             dsp_dec_o,
    output logic [PTR_W-1:0] ptr_ld_val_o,
    output logic             mem_en_o,
    output logic             mem_we_o,
    output logic [PTR_W-1:0] mem_addr_o,
    output logic [7:0]       mem_wdata_o,
    output logic             c_o,
    output logic             z_o,
    output logic [7:0]       pop_data_o,
    output logic             pop_valid_o
);

    localparam int PAGE_W = PC_W - LO_W;

    st_e             st_q;
    op_e             op;
    logic            accept;
    logic [7:0]      frm_lo_q;
    logic [7:0]      frm_hi_q;
    logic [PC_W-1:0] tgt_q;
    logic [7:0]      push_q;
    logic            reti_q;
    logic            c_q;
    logic            z_q;

    assign op     = op_e'(op_code_i);
    assign accept = op_valid_i && (st_q == ST_IDLE);

    // State register and captured operands of the running operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            frm_lo_q <= '0;
            frm_hi_q <= '0;
            tgt_q    <= '0;
            push_q   <= '0;
            reti_q   <= 1'b0;
            c_q      <= 1'b0;
            z_q      <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (op_valid_i) begin
                        case (op)
                            OP_CALL, OP_INTACK: begin
                                frm_lo_q <= pc_i[LO_W-1:0];
                                frm_hi_q <= {c_in_i, z_in_i, pc_i[PC_W-1:LO_W]};
                                tgt_q    <= op_target_i;
                                st_q     <= ST_SAV_LO;
                            end
                            OP_RET, OP_RETI: begin
                                reti_q <= (op == OP_RETI);
                                st_q   <= ST_RD_HI;
                            end
                            OP_PUSH: begin
                                push_q <= op_data_i;
                                st_q   <= ST_PUSH;
                            end
                            OP_POP:  st_q <= ST_POP_RD;
                            default: st_q <= ST_IDLE;
                        endcase
                    end
                end
                ST_SAV_LO: st_q <= ST_SAV_HI;
                ST_SAV_HI: st_q <= ST_IDLE;
                ST_RD_HI:  st_q <= ST_RD_LO;
                ST_RD_LO: begin
                    frm_hi_q <= mem_rdata_i;
                    st_q     <= ST_RD_FIN;
                end
                ST_RD_FIN: begin
                    if (reti_q) begin
                        c_q <= frm_hi_q[7];
                        z_q <= frm_hi_q[6];
                    end
                    st_q <= ST_IDLE;
                end
                ST_PUSH:   st_q <= ST_IDLE;
                ST_POP_RD: st_q <= ST_POP_DT;
                ST_POP_DT: st_q <= ST_IDLE;
                default:   st_q <= ST_IDLE;
            endcase
        end
    end

    // Single-cycle requests taken while idle.
    always_comb begin
        step_o       = accept && (op == OP_STEP);
        page_o       = accept && (op == OP_PAGE);
        psp_ld_o     = accept && (op == OP_LDPSP);
        dsp_ld_o     = accept && (op == OP_LDDSP);
        ptr_ld_val_o = op_data_i;
    end

    // Pointer movement during the busy cycles.
    always_comb begin
        psp_inc_o = (st_q == ST_SAV_LO) || (st_q == ST_SAV_HI);
        psp_dec_o = (st_q == ST_RD_HI) || (st_q == ST_RD_LO);
        dsp_dec_o = (st_q == ST_PUSH);
        dsp_inc_o = (st_q == ST_POP_RD);
    end

    // RAM port: address, direction and write data for each busy cycle.
    always_comb begin
        mem_en_o    = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        case (st_q)
            ST_SAV_LO: begin
                mem_en_o    = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = psp_i;
                mem_wdata_o = frm_lo_q;
            end
            ST_SAV_HI: begin
                mem_en_o    = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = psp_i;
                mem_wdata_o = frm_hi_q;
            end
            ST_RD_HI, ST_RD_LO: begin
                mem_en_o   = 1'b1;
                mem_addr_o = psp_i - 1'b1;
            end
            ST_PUSH: begin
                mem_en_o    = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = dsp_i - 1'b1;
                mem_wdata_o = push_q;
            end
            ST_POP_RD: begin
                mem_en_o   = 1'b1;
                mem_addr_o = dsp_i;
            end
            default: ;
        endcase
    end

    // Counter reload at the end of a save (target) or a restore (frame).
    always_comb begin
        pc_ld_o     = (st_q == ST_SAV_HI) || (st_q == ST_RD_FIN);
        pc_ld_val_o = (st_q == ST_SAV_HI) ? tgt_q
                                           : {frm_hi_q[PAGE_W-1:0], mem_rdata_i};
    end

    assign busy_o      = (st_q != ST_IDLE);
    assign c_o         = c_q;
    assign z_o         = z_q;
    assign pop_data_o  = mem_rdata_i;
    assign pop_valid_o = (st_q == ST_POP_DT);

    AST_SAVE_TWO_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SAV_LO) |=> (mem_we_o && busy_o && (mem_addr_o == PTR_W'($past(psp_i) + 1'b1)))); // R4

    AST_FLAGS_ONLY_ON_RETI: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({c_q, z_q}) |-> ($past(st_q) == ST_RD_FIN && $past(reti_q))); // R6

    AST_PUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PUSH) |=> !busy_o); // R11

endmodule

// File: rtl/pcs_top.sv
// Module: pcs_top
// Program counter and dual stack unit: connects the sequencer, the program
// counter and the two stack pointers. Assumes a single-port 256-byte RAM
// outside the unit, with one cycle of read latency.
module pcs_top
    import pcs_pkg::*;
#(
    parameter int PC_W  = PCS_PC_W,
    parameter int LO_W  = PCS_LO_W,
    parameter int PTR_W = PCS_PTR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid_i,
    input  logic [3:0]       op_code_i,
    input  logic [7:0]       op_data_i,
    input  logic [PC_W-1:0]  op_target_i,
    input  logic             c_in_i,
    input  logic             z_in_i,
    output logic [PC_W-1:0]  pc_o,
    output logic             c_o,
    output logic             z_o,
    output logic             busy_o,
    output logic [PTR_W-1:0] psp_o,
    output logic [PTR_W-1:0] dsp_o,
    output logic [7:0]       pop_data_o,
    output logic             pop_valid_o,
    output logic             mem_en_o,
    output logic             mem_we_o,
    output logic [PTR_W-1:0] mem_addr_o,
    output logic [7:0]       mem_wdata_o,
    input  logic [7:0]       mem_rdata_i
);

    logic             step, page, pc_ld;
    logic [PC_W-1:0]  pc_ld_val;
    logic             psp_ld, psp_inc, psp_dec;
    logic             dsp_ld, dsp_inc, dsp_dec;
    logic [PTR_W-1:0] ptr_ld_val;

    pcs_seq #(.PC_W(PC_W), .LO_W(LO_W), .PTR_W(PTR_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_valid_i   (op_valid_i),
        .op_code_i    (op_code_i),
        .op_data_i    (op_data_i),
        .op_target_i  (op_target_i),
        .c_in_i       (c_in_i),
        .z_in_i       (z_in_i),
        .pc_i         (pc_o),
        .psp_i        (psp_o),
        .dsp_i        (dsp_o),
        .mem_rdata_i  (mem_rdata_i),
        .busy_o       (busy_o),
        .step_o       (step),
        .page_o       (page),
        .pc_ld_o      (pc_ld),
        .pc_ld_val_o  (pc_ld_val),
        .psp_ld_o     (psp_ld),
        .psp_inc_o    (psp_inc),
        .psp_dec_o    (psp_dec),
        .dsp_ld_o     (dsp_ld),
        .dsp_inc_o    (dsp_inc),
        .dsp_dec_o    (dsp_dec),
        .ptr_ld_val_o (ptr_ld_val),
        .mem_en_o     (mem_en_o),
        .mem_we_o     (mem_we_o),
        .mem_addr_o   (mem_addr_o),
        .mem_wdata_o  (mem_wdata_o),
        .c_o          (c_o),
        .z_o          (z_o),
        .pop_data_o   (pop_data_o),
        .pop_valid_o  (pop_valid_o)
    );

    pcs_pc #(.PC_W(PC_W), .LO_W(LO_W)) u_pc (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (step),
        .page_i     (page),
        .load_i     (pc_ld),
        .load_val_i (pc_ld_val),
        .pc_o       (pc_o)
    );

    pcs_ptr #(.W(PTR_W)) u_psp (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_i     (psp_ld),
        .ld_val_i (ptr_ld_val),
        .inc_i    (psp_inc),
        .dec_i    (psp_dec),
        .ptr_o    (psp_o)
    );

    pcs_ptr #(.W(PTR_W)) u_dsp (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_i     (dsp_ld),
        .ld_val_i (ptr_ld_val),
        .inc_i    (dsp_inc),
        .dec_i    (dsp_dec),
        .ptr_o    (dsp_o)
    );

    AST_BUSY_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !pc_ld) |=> $stable(pc_o)); // R11

endmodule

// File: tb/tb_pcs_top.sv
// Scoreboard bench: the driver queues the expected RAM accesses, and a
// monitor compares each access the unit makes against that queue.
module tb_pcs_top;

    typedef struct packed {
        logic       we;
        logic [7:0] addr;
        logic [7:0] data;
    } mem_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid_i = 1'b0;
    logic [3:0]  op_code_i = 4'd0;
    logic [7:0]  op_data_i = 8'd0;
    logic [13:0] op_target_i = 14'd0;
    logic        c_in_i = 1'b0;
    logic        z_in_i = 1'b0;
    logic [13:0] pc_o;
    logic        c_o, z_o, busy_o, pop_valid_o;
    logic [7:0]  psp_o, dsp_o, pop_data_o;
    logic        mem_en_o, mem_we_o;
    logic [7:0]  mem_addr_o, mem_wdata_o;
    logic [7:0]  mem_rdata_i = 8'd0;
    logic [7:0]  ram [256];

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;
    mem_item_t exp_q[$];

    always #2 clk = ~clk;

    pcs_top dut (.*);

    // RAM model: one cycle of read latency.
    always @(posedge clk) begin
        if (mem_en_o) begin
            if (mem_we_o) ram[mem_addr_o] <= mem_wdata_o;
            else          mem_rdata_i <= ram[mem_addr_o];
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: each RAM access is compared with the next expected item.
    always @(negedge clk) begin
        if (rst_n && mem_en_o) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_errors++;
                $display("FAIL R4 unexpected access actual=%0h expected=none",
                         {mem_we_o, mem_addr_o, mem_wdata_o});
            end else begin
                mem_item_t e;
                e = exp_q.pop_front();
                if (mem_we_o !== e.we || mem_addr_o !== e.addr ||
                    (e.we && mem_wdata_o !== e.data)) begin
                    n_errors++;
                    $display("FAIL R4 memory access actual=%0h expected=%0h",
                             {mem_we_o, mem_addr_o, mem_we_o ? mem_wdata_o : 8'h00},
                             {e.we, e.addr, e.we ? e.data : 8'h00});
                end
            end
        end
    end

    task automatic exp_w(input logic [7:0] a, input logic [7:0] d);
        exp_q.push_back('{we: 1'b1, addr: a, data: d});
    endtask

    task automatic exp_r(input logic [7:0] a);
        exp_q.push_back('{we: 1'b0, addr: a, data: 8'h00});
    endtask

    // Driver: issue one operation and wait for the unit to be idle again.
    task automatic issue(input logic [3:0] op, input logic [7:0] d, input logic [13:0] t,
                         input logic c, input logic z, output int bcyc, output logic [7:0] popd);
        @(negedge clk);
        op_valid_i  = 1'b1;
        op_code_i   = op;
        op_data_i   = d;
        op_target_i = t;
        c_in_i      = c;
        z_in_i      = z;
        @(negedge clk);
        op_valid_i = 1'b0;
        bcyc = 0;
        popd = 8'h00;
        while (busy_o) begin
            bcyc++;
            if (pop_valid_o) popd = pop_data_o;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        int bc;
        logic [7:0] pd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 pc", pc_o, 14'h0000);
        check("R1 psp", psp_o, 8'h00);
        check("R1 dsp", dsp_o, 8'h00);
        check("R1 flags", {c_o, z_o}, 2'b00);
        check("R1 busy", busy_o, 1'b0);

        // R7 first push lands at 0xFF; R12 code 7
        exp_w(8'hFF, 8'hA5);
        issue(4'd7, 8'hA5, 14'h0, 1'b0, 1'b0, bc, pd);
        check("R7 dsp after push", dsp_o, 8'hFF);
        check("R11 push busy cycles", bc, 1);
        // R8 pop reads back and R10 wraps dsp to 0x00
        exp_r(8'hFF);
        issue(4'd8, 8'h00, 14'h0, 1'b0, 1'b0, bc, pd);
        check("R8 pop data", pd, 8'hA5);
        check("R10 dsp wraps", dsp_o, 8'h00);
        check("R11 pop busy cycles", bc, 2);

        // R2 steps
        for (int i = 0; i < 3; i++) issue(4'd1, 8'h00, 14'h0, 1'b0, 1'b0, bc, pd);
        check("R2 three steps", pc_o, 14'h0003);

        // R4 call frame
        exp_w(8'h00, 8'h03);
        exp_w(8'h01, 8'h80);
        issue(4'd3, 8'h00, 14'h12FF, 1'b1, 1'b0, bc, pd);
        check("R4 pc target", pc_o, 14'h12FF);
        check("R4 psp plus two", psp_o, 8'h02);
        check("R11 call busy cycles", bc, 2);

        // R2 low byte wraps without page carry
        issue(4'd1, 8'h00, 14'h0, 1'b0, 1'b0, bc, pd);
        check("R2 step wrap", pc_o, 14'h1200);
        // R3 page operation
        issue(4'd2, 8'h00, 14'h0, 1'b0, 1'b0, bc, pd);
        check("R3 page", pc_o, 14'h1301);

        // R4 interrupt frame nested on the call frame
        exp_w(8'h02, 8'h01);
        exp_w(8'h03, 8'h53);
        issue(4'd4, 8'h00, 14'h0040, 1'b0, 1'b1, bc, pd);
        check("R4 vector", pc_o, 14'h0040);
        check("R4 psp four", psp_o, 8'h04);

        // R5 return-from-interrupt
        exp_r(8'h03);
        exp_r(8'h02);
        issue(4'd6, 8'h00, 14'h0, 1'b0, 1'b0, bc, pd);
        check("R5 pc restored", pc_o, 14'h1301);
        check("R5 flags restored", {c_o, z_o}, 2'b01);
        check("R5 psp minus two", psp_o, 8'h02);
        check("R11 return busy cycles", bc, 3);

        // R6 return-from-subroutine keeps flags
        exp_r(8'h01);
        exp_r(8'h00);
        issue(4'd5, 8'h00, 14'h0, 1'b0, 1'b0, bc, pd);
        check("R6 pc restored", pc_o, 14'h0003);
        check("R6 flags kept", {c_o, z_o}, 2'b01);
        check("R6 psp zero", psp_o, 8'h00);

        // R9 direct PSP load, then R10 frame across the boundary
        issue(4'd9, 8'hFF, 14'h0, 1'b0, 1'b0, bc, pd);
        check("R9 psp load", psp_o, 8'hFF);
        check("R9 no busy", bc, 0);
        exp_w(8'hFF, 8'h03);
        exp_w(8'h00, 8'hC0);
        issue(4'd3, 8'h00, 14'h3F10, 1'b1, 1'b1, bc, pd);
        check("R10 psp wraps up", psp_o, 8'h01);
        // R3 page field wraps
        issue(4'd2, 8'h00, 14'h0, 1'b0, 1'b0, bc, pd);
        check("R3 page wrap", pc_o, 14'h0011);
        exp_r(8'h00);
        exp_r(8'hFF);
        issue(4'd6, 8'h00, 14'h0, 1'b0, 1'b0, bc, pd);
        check("R10 restore across wrap", pc_o, 14'h0003);
        check("R5 flags both set", {c_o, z_o}, 2'b11);
        check("R10 psp wraps down", psp_o, 8'hFF);

        // R9 DSP load, R7/R8 ordering
        issue(4'd10, 8'h10, 14'h0, 1'b0, 1'b0, bc, pd);
        check("R9 dsp load", dsp_o, 8'h10);
        exp_w(8'h0F, 8'h5A);
        issue(4'd7, 8'h5A, 14'h0, 1'b0, 1'b0, bc, pd);
        exp_w(8'h0E, 8'h6B);
        issue(4'd7, 8'h6B, 14'h0, 1'b0, 1'b0, bc, pd);
        check("R7 dsp two pushes", dsp_o, 8'h0E);
        exp_r(8'h0E);
        issue(4'd8, 8'h00, 14'h0, 1'b0, 1'b0, bc, pd);
        check("R8 last in first out", pd, 8'h6B);
        exp_r(8'h0F);
        issue(4'd8, 8'h00, 14'h0, 1'b0, 1'b0, bc, pd);
        check("R8 second pop", pd, 8'h5A);
        check("R8 dsp restored", dsp_o, 8'h10);

        // R11 a step held during a busy push is ignored
        exp_w(8'h0F, 8'h77);
        @(negedge clk);
        op_valid_i = 1'b1;
        op_code_i  = 4'd7;
        op_data_i  = 8'h77;
        @(negedge clk);
        check("R11 busy during push", busy_o, 1'b1);
        op_code_i = 4'd1;
        @(negedge clk);
        op_valid_i = 1'b0;
        check("R11 step ignored", pc_o, 14'h0003);
        check("R11 dsp after push", dsp_o, 8'h0F);

        repeat (3) @(negedge clk);
        check("R4 all accesses seen", exp_q.size(), 0);
        done = 1'b1;
        finish_run();
    end

endmodule